// File: doc/BRIEF.md
# Audio System Reset Sequencer

This block produces the internal system reset for an audio DSP and codec pair. Three control bits from the register file drive it: a clock-enable bit, a codec-run bit and a DSP-run bit. A PLL lock indicator and the frame clock (LRCK) are its other inputs. While the clock is enabled and neither run bit is set, the system sits in reset. Program and coefficient memories may be loaded only in that state, and only once the PLL is considered stable. The PLL is stable when a programmable wait has elapsed since the clock was enabled, or as soon as the lock indicator goes high.

Setting either run bit requests release. In master mode the release takes effect on the next clock edge. In slave mode it waits for the frame-start edge of LRCK. That edge is rising for left-justified style formats and falling when the I2S format is selected.

While running in slave mode, the block keeps measuring the frame period. It forces the system back into reset if LRCK stops, or if a frame-start edge lands more than a quarter of a frame away from where it was expected. It then releases again on the next frame-start edge, with no action from software.

Top module: `audio_sysrst_seq`

## Requirements
- R1: `mem_access_ok` is high exactly when, one cycle earlier, `clk_en_bit` was 1, `codec_run_bit` and `dsp_run_bit` were both 0, and the PLL was stable.
- R2: The PLL counts as stable once `clk_en_bit` has been 1 for `PLL_WAIT` cycles, or after the two-flop-synchronised `pll_lock` is high, whichever is first. Stability is lost whenever `clk_en_bit` is 0.
- R3: After `rst`, `sys_rst` is 1 and the other two outputs are 0. `sys_rst` is 1 in the cycle after any cycle in which `clk_en_bit` is 0 or both run bits are 0.
- R4: In master mode (`slave_mode`=0), `sys_rst` falls in the cycle after `clk_en_bit` is 1 and either run bit is 1.
- R5: In slave mode with `fmt_i2s`=0, release waits for an LRCK rising edge. It happens three clock edges after that edge, through the synchroniser and the edge detector.
- R6: In slave mode with `fmt_i2s`=1, release happens on an LRCK falling edge instead, with the same latency.
- R7: `run_start` is a single-cycle pulse, asserted exactly in the first cycle in which `sys_rst` is 0.
- R8: While running in slave mode, `sys_rst` returns to 1 when no frame-start edge has arrived for (measured period + `STOP_MARGIN`) cycles. Before a period has been measured, the limit is `MAX_FRAME` cycles.
- R9: While running in slave mode, a frame-start edge whose distance from the previous one differs from the measured period by more than a quarter of that period returns `sys_rst` to 1. A smaller deviation is tolerated.
- R10: After an automatic return to reset under R8 or R9, `sys_rst` falls again at the next frame-start edge, provided a run bit is still set.
- R11: In master mode, LRCK is ignored: a stopped LRCK does not reassert `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_bit | input | 1 | Clock-enable control bit; 0 holds clock reset |
| codec_run_bit | input | 1 | Codec run request bit |
| dsp_run_bit | input | 1 | DSP run request bit |
| pll_lock | input | 1 | PLL lock indicator, asynchronous |
| fmt_i2s | input | 1 | 1 selects I2S format (falling frame-start edge) |
| slave_mode | input | 1 | 1 selects slave mode (external LRCK) |
| lrck | input | 1 | Frame clock, asynchronous |
| sys_rst | output | 1 | Internal system reset, active high |
| mem_access_ok | output | 1 | Program/coefficient memory access permitted |
| run_start | output | 1 | One-cycle pulse at system release |

## Verification
The bench tests the edge polarity against the format by arming the run request right after a rising edge in I2S mode. A design that uses the wrong polarity releases half a frame late. It stops LRCK straight after a frame-start edge and samples on both sides of the period-plus-margin limit. That catches a design that never times out, or one that times out on the nominal half frame. It shifts one frame edge early, once by less and once by more than a quarter frame, so a missing tolerance gives either a false reset or a missed one. It also checks that release happens again on the next edge after each fault, and that master mode stays running with LRCK dead.

// File: rtl/arst_pkg.sv
package arst_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_RUN   = 2'd2
  } arst_state_t;
endpackage

// File: rtl/arst_sync2.sv
module arst_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/arst_pll_gate.sv
module arst_pll_gate #(
  parameter int PLL_WAIT = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  logic lock_s,
  output logic stable
);
  localparam int PW = $clog2(PLL_WAIT + 1);
  logic [PW-1:0] wait_cnt;
  logic          wait_done;

  assign wait_done = (wait_cnt == PW'(PLL_WAIT));

  always_ff @(posedge clk) begin
    if (rst || !clk_en) begin
      wait_cnt <= '0;
      stable   <= 1'b0;
    end else begin
      if (!wait_done) wait_cnt <= wait_cnt + 1'b1;
      stable <= stable | lock_s | wait_done;
    end
  end
endmodule

// File: rtl/arst_frame_mon.sv
module arst_frame_mon #(
  parameter int CNT_W       = 14,
  parameter int STOP_MARGIN = 16,
  parameter int MAX_FRAME   = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic i2s,
  input  logic lrck_s,
  output logic start_edge,
  output logic fault
);
  localparam int LIM_W = CNT_W + 1;

  logic             prev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic             armed;
  logic             valid;
  logic             lost;
  logic             rise;
  logic             fall;
  logic [LIM_W-1:0] limit;
  logic [CNT_W-1:0] dev;
  logic             phase_bad;

  assign rise       = lrck_s & ~prev;
  assign fall       = ~lrck_s & prev;
  assign start_edge = i2s ? fall : rise;

  assign limit = valid ? ({1'b0, period} + LIM_W'(STOP_MARGIN)) : LIM_W'(MAX_FRAME);
  assign dev   = (cnt >= period) ? (cnt - period) : (period - cnt);
  assign phase_bad = start_edge && armed && valid && !lost && (dev > (period >> 2));
  assign fault = lost | phase_bad;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lrck_s;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt    <= '0;
      period <= '0;
      armed  <= 1'b0;
      valid  <= 1'b0;
      lost   <= 1'b0;
    end else if (start_edge) begin
      cnt   <= '0;
      armed <= 1'b1;
      lost  <= 1'b0;
      if (armed && !lost) begin
        period <= cnt;
        valid  <= 1'b1;
      end else begin
        valid  <= 1'b0;
      end
    end else begin
      if (cnt != '1) cnt <= cnt + 1'b1;
      if ({1'b0, cnt} >= limit) lost <= 1'b1;
    end
  end
endmodule

// File: rtl/audio_sysrst_seq.sv
module audio_sysrst_seq #(
  parameter int PLL_WAIT    = 1250000,
  parameter int CNT_W       = 14,
  parameter int STOP_MARGIN = 16,
  parameter int MAX_FRAME   = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_en_bit,
  input  logic codec_run_bit,
  input  logic dsp_run_bit,
  input  logic pll_lock,
  input  logic fmt_i2s,
  input  logic slave_mode,
  input  logic lrck,
  output logic sys_rst,
  output logic mem_access_ok,
  output logic run_start
);
  import arst_pkg::*;

  logic [1:0]  sync_q;
  logic        lock_s;
  logic        lrck_s;
  logic        pll_ok;
  logic        start_edge;
  logic        mon_fault;
  logic        run_req;
  logic        mon_clear;
  arst_state_t state;
  arst_state_t state_nxt;

  arst_sync2 #(.WIDTH(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pll_lock, lrck}),
    .q   (sync_q)
  );
  assign lock_s = sync_q[1];
  assign lrck_s = sync_q[0];

  arst_pll_gate #(.PLL_WAIT(PLL_WAIT)) u_pll (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en_bit),
    .lock_s (lock_s),
    .stable (pll_ok)
  );

  assign mon_clear = (state == ST_HOLD) || !slave_mode;

  arst_frame_mon #(
    .CNT_W      (CNT_W),
    .STOP_MARGIN(STOP_MARGIN),
    .MAX_FRAME  (MAX_FRAME)
  ) u_mon (
    .clk        (clk),
    .rst        (rst),
    .clear      (mon_clear),
    .i2s        (fmt_i2s),
    .lrck_s     (lrck_s),
    .start_edge (start_edge),
    .fault      (mon_fault)
  );

  assign run_req = clk_en_bit & (codec_run_bit | dsp_run_bit);

  always_comb begin
    state_nxt = state;
    case (state)
      ST_HOLD: begin
        if (run_req) state_nxt = slave_mode ? ST_ALIGN : ST_RUN;
      end
      ST_ALIGN: begin
        if (!run_req)                     state_nxt = ST_HOLD;
        else if (!slave_mode || start_edge) state_nxt = ST_RUN;
      end
      ST_RUN: begin
        if (!run_req)                     state_nxt = ST_HOLD;
        else if (slave_mode && mon_fault) state_nxt = ST_ALIGN;
      end
      default: state_nxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_HOLD;
      sys_rst       <= 1'b1;
      run_start     <= 1'b0;
      mem_access_ok <= 1'b0;
    end else begin
      state         <= state_nxt;
      sys_rst       <= (state_nxt != ST_RUN);
      run_start     <= (state_nxt == ST_RUN) && (state != ST_RUN);
      mem_access_ok <= clk_en_bit & ~codec_run_bit & ~dsp_run_bit & pll_ok;
    end
  end
endmodule

// File: rtl/audio_sysrst_seq_chk.sv
module audio_sysrst_seq_chk (
  input logic clk,
  input logic rst,
  input logic clk_en_bit,
  input logic codec_run_bit,
  input logic dsp_run_bit,
  input logic sys_rst,
  input logic mem_access_ok,
  input logic run_start
);
  assert_pulse_edge_R7: assert property (@(posedge clk) disable iff (rst)
    run_start |-> (!sys_rst && $past(sys_rst)));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    run_start |=> !run_start);

  assert_mem_in_reset_R1: assert property (@(posedge clk) disable iff (rst)
    mem_access_ok |-> sys_rst);

  assert_mem_blocked_R1: assert property (@(posedge clk) disable iff (rst)
    (codec_run_bit || dsp_run_bit) |=> !mem_access_ok);

  assert_bits_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!codec_run_bit && !dsp_run_bit) |=> sys_rst);

  assert_clk_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !clk_en_bit |=> (sys_rst && !mem_access_ok));
endmodule

bind audio_sysrst_seq audio_sysrst_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .clk_en_bit    (clk_en_bit),
  .codec_run_bit (codec_run_bit),
  .dsp_run_bit   (dsp_run_bit),
  .sys_rst       (sys_rst),
  .mem_access_ok (mem_access_ok),
  .run_start     (run_start)
);

// File: tb/audio_sysrst_seq_test.sv
`timescale 1ns/1ps
module audio_sysrst_seq_test;
  localparam int PLL_WAIT = 200;
  localparam int HALF     = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en_bit = 1'b0;
  logic codec_run_bit = 1'b0;
  logic dsp_run_bit = 1'b0;
  logic pll_lock = 1'b0;
  logic fmt_i2s = 1'b0;
  logic slave_mode = 1'b0;
  logic lrck = 1'b0;
  logic sys_rst;
  logic mem_access_ok;
  logic run_start;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  bit done = 1'b0;
  logic lr_run = 1'b0;
  int lr_cnt = 0;
  int half_len = HALF;

  always #4 clk = ~clk;

  audio_sysrst_seq #(
    .PLL_WAIT(PLL_WAIT), .CNT_W(10), .STOP_MARGIN(8), .MAX_FRAME(100)
  ) uut (
    .clk(clk), .rst(rst), .clk_en_bit(clk_en_bit), .codec_run_bit(codec_run_bit),
    .dsp_run_bit(dsp_run_bit), .pll_lock(pll_lock), .fmt_i2s(fmt_i2s),
    .slave_mode(slave_mode), .lrck(lrck), .sys_rst(sys_rst),
    .mem_access_ok(mem_access_ok), .run_start(run_start)
  );

  always @(negedge clk) begin
    if (lr_run) begin
      if (lr_cnt >= half_len - 1) begin
        lrck   <= ~lrck;
        lr_cnt <= 0;
      end else begin
        lr_cnt <= lr_cnt + 1;
      end
    end
  end

  always @(negedge clk) if (!rst && run_start) starts <= starts + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // {clk_en, codec, dsp, exp_mem, exp_sys_rst}; master mode, lock high
  localparam logic [4:0] VEC [7] = '{
    5'b100_11, 5'b110_00, 5'b101_00, 5'b111_00,
    5'b011_01, 5'b000_01, 5'b100_11
  };

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R3 reset sys_rst", sys_rst, 1'b1);
    check("R3 reset mem", mem_access_ok, 1'b0);
    check("R3 reset run_start", run_start, 1'b0);

    // R2: timer path, lock low
    clk_en_bit = 1'b1;
    tick(PLL_WAIT - 20);
    check("R2 before wait", mem_access_ok, 1'b0);
    tick(30);
    check("R2 after wait", mem_access_ok, 1'b1);

    // R2: lock path shortcuts the wait
    clk_en_bit = 1'b0;
    tick(3);
    check("R1 clock bit low", mem_access_ok, 1'b0);
    pll_lock = 1'b1;
    clk_en_bit = 1'b1;
    tick(6);
    check("R2 lock shortcut", mem_access_ok, 1'b1);

    // Vector table: R1, R3, R4
    for (int i = 0; i < 7; i++) begin
      clk_en_bit    = VEC[i][4];
      codec_run_bit = VEC[i][3];
      dsp_run_bit   = VEC[i][2];
      tick(5);
      check($sformatf("R1 vec %0d mem", i), mem_access_ok, VEC[i][1]);
      check($sformatf("R4 vec %0d sys_rst", i), sys_rst, VEC[i][0]);
    end

    // R5: slave, rising edge
    slave_mode = 1'b1;
    codec_run_bit = 1'b1;
    tick(10);
    check("R5 no edge yet", sys_rst, 1'b1);
    starts = 0;
    lr_run = 1'b1;
    @(posedge lrck);
    tick(1);
    check("R5 not before sync", sys_rst, 1'b1);
    tick(4);
    check("R5 released on rising", sys_rst, 1'b0);
    check_int("R7 one pulse", starts, 1);

    // R9: steady frames, then a small early shift, tolerated
    tick(6 * 2 * HALF);
    check("R9 steady run", sys_rst, 1'b0);
    @(posedge lrck);
    half_len = HALF - 8;
    @(negedge lrck);
    half_len = HALF;
    @(posedge lrck);
    tick(10);
    check("R9 small shift tolerated", sys_rst, 1'b0);
    tick(3 * 2 * HALF);
    check("R9 stays running", sys_rst, 1'b0);

    // R9: large early shift
    @(posedge lrck);
    half_len = HALF - 24;
    @(negedge lrck);
    half_len = HALF;
    @(posedge lrck);
    tick(8);
    check("R9 large shift resets", sys_rst, 1'b1);
    starts = 0;
    @(posedge lrck);
    tick(6);
    check("R10 release after phase fault", sys_rst, 1'b0);
    check_int("R7 pulse after phase fault", starts, 1);

    // R8: stop LRCK right after a rising edge
    tick(3 * 2 * HALF);
    @(posedge lrck);
    lr_run = 1'b0;
    tick(50);
    check("R8 within limit", sys_rst, 1'b0);
    tick(40);
    check("R8 stopped LRCK resets", sys_rst, 1'b1);
    lr_run = 1'b1;
    tick(40);
    check("R10 wait for rising", sys_rst, 1'b1);
    tick(30);
    check("R10 release after resume", sys_rst, 1'b0);

    // R6: I2S, falling edge
    codec_run_bit = 1'b0;
    tick(3);
    check("R3 run bits cleared", sys_rst, 1'b1);
    fmt_i2s = 1'b1;
    @(posedge lrck);
    dsp_run_bit = 1'b1;
    tick(20);
    check("R6 waiting for falling", sys_rst, 1'b1);
    tick(17);
    check("R6 released on falling", sys_rst, 1'b0);
    tick(3 * 2 * HALF);
    check("R6 keeps running", sys_rst, 1'b0);

    // R11: master mode ignores LRCK
    slave_mode = 1'b0;
    lr_run = 1'b0;
    tick(300);
    check("R11 master ignores stop", sys_rst, 1'b0);

    // R3: clock bit drop
    clk_en_bit = 1'b0;
    tick(2);
    check("R3 clock bit forces reset", sys_rst, 1'b1);
    check("R1 no access without clock", mem_access_ok, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule